// File: doc/BRIEF.md
# SD Card Command-Line Sequencer

This block runs the command side of an SD card bus: it produces the card clock and drives or listens on the bidirectional command line. Software starts work by writing a control word that contains single-bit trigger flags. The available phases are a power-up clock burst, transmission of one command frame, reception of a short or long response, and a short trailing clock burst. Each trigger clears itself when its own phase completes. Several triggers set in one write run back to back in a fixed order, and a one-cycle done pulse marks the end of the last phase.

The card clock runs at half the system clock rate. The host changes the command line only after a falling card-clock edge and samples the line on rising edges. A keep-running bit chooses between two clock modes: the clock runs only while a phase is active, or it runs all the time. A soft-reset bit in the same word drops every pending trigger and abandons the phase in progress. Two data-transfer request flags are only stored and shown as pending; this block does not act on them.

Top module: `sdcmd_seq`

## Requirements
- R1: Out of reset, sd_clk is 0, cmd_oe is 0, cmd_out is 1, busy and done are 0, and trig_pend is 0.
- R2: Control bit 7 (keep) selects the clock mode. With keep at 0, sd_clk stays low while no phase runs. With keep at 1, sd_clk toggles on every system clock cycle.
- R3: Control bit 5 starts a burst of exactly 74 card-clock periods with cmd_oe low. At the end of the burst, bit 5 of trig_pend clears and done pulses.
- R4: Control bit 6 starts a burst of exactly 8 card-clock periods, after which bit 6 of trig_pend clears.
- R5: Control bit 0 sends a 48-bit frame MSB first on cmd_out with cmd_oe high. The frame is: 0, 1, the index from control bits 13:8, the 32-bit cmd_arg, a CRC-7 (polynomial x^7+x^3+1, initial value 0) computed over the first 40 bits, then 1. Each bit changes only after a falling sd_clk edge and is held for one card-clock period.
- R6: Control bit 1 receives a short response. The first 0 sampled on a rising edge is the start bit, and 47 bits follow it. resp_data[38:0] holds the 39 bits that come before the CRC-7 field, with the upper bits of resp_data cleared to 0.
- R7: Control bit 4 receives a long response of 135 bits after the start bit. resp_data[126:0] holds the 127 bits before the CRC-7, the CRC-7 is not stored, and no CRC check is made.
- R8: If no start bit is sampled within 64 rising edges, the phase ends after 64 card-clock periods, resp_timeout is set, and trig_pend bits 1 and 4 clear.
- R9: On a short response, resp_crc_err is set when the received CRC-7 differs from the CRC-7 computed over the 39 captured bits. It is clear when the two match.
- R10: When several triggers are set together, the phases run in the order 74-clock burst, command, response, 8-clock burst, with no gap between them. busy stays high throughout, and done pulses once, one cycle after the last phase ends.
- R11: A write with control bit 14 at 0 never clears a pending trigger. Writing 0 to trigger bits has no effect on a running sequence.
- R12: A write with control bit 14 at 1 clears every pending trigger, aborts the phase in progress, and returns the block to idle without a done pulse.
- R13: Control bits 2 and 3 are only stored as pending request flags. They start no phase and stay set until a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word: triggers, keep, index, soft reset |
| cmd_arg | input | 32 | Command argument, sampled when the command phase starts |
| cmd_in | input | 1 | Command line as seen from the card |
| sd_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line value driven by the host |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | A phase is running |
| done | output | 1 | One-cycle pulse when the sequence ends |
| resp_timeout | output | 1 | No start bit arrived in the last response phase |
| resp_crc_err | output | 1 | Short response CRC-7 mismatch |
| trig_pend | output | 7 | Pending trigger flags (control bits 6:0) |
| resp_data | output | 128 | Captured response payload, right-aligned |

## Verification
The hardest condition to reach from the ports is a response whose start bit lands on the 64th and last allowed rising edge. The very next edge would instead produce a timeout, so being off by one cycle changes the result. The bench therefore schedules the card's replies per card-clock period, working from a per-cycle model of the whole sequence, and places start bits at delays 0, 3 and 63. It also withholds a start bit completely. A write of zero triggers in the middle of a burst checks that an ongoing chain continues unchanged.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_CMD,
    ST_RSP,
    ST_TAIL
  } phase_e;

  localparam int TB_CMD  = 0;
  localparam int TB_RSP  = 1;
  localparam int TB_DIN  = 2;
  localparam int TB_DOUT = 3;
  localparam int TB_LONG = 4;
  localparam int TB_INIT = 5;
  localparam int TB_TAIL = 6;
  localparam int CB_KEEP = 7;
  localparam int CB_IDX  = 8;
  localparam int CB_SRST = 14;
  localparam int IDX_W   = 6;
  localparam int ARG_W   = 32;
  localparam int TRIG_W  = 7;
  localparam int FRAME_W = 48;

  // CRC-7, x^7 + x^3 + 1, serial form, MSB first
  function automatic logic [6:0] crc7_of(input logic [39:0] msg);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = msg[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic run,
  output logic sd_clk,
  output logic rise,
  output logic fall
);

  logic ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (abort)    ph_d = 1'b0;
    else if (run) ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign sd_clk = ph_q;
  assign rise   = run & ~ph_q;
  assign fall   = run & ph_q;

  AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    run && !abort |=> sd_clk != $past(sd_clk)); // R2
  AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !abort |=> $stable(sd_clk)); // R2

endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             load,
  input  logic             active,
  input  logic             fall,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             bit_o,
  output logic             last_o
);

  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [39:0]        head;

  assign head   = {1'b0, 1'b1, idx, arg};
  assign last_o = active & fall & (cnt_q == CNT_W'(FRAME_W - 1));
  assign bit_o  = sh_q[FRAME_W-1];

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (abort) begin
      sh_d  = '1;
      cnt_d = '0;
    end else if (load) begin
      sh_d  = {head, crc7_of(head), 1'b1};
      cnt_d = '0;
    end else if (active && fall) begin
      sh_d  = {sh_q[FRAME_W-2:0], 1'b1};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    active && !fall && !load && !abort |=> $stable(bit_o)); // R5

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx #(
  parameter int RESP_W     = 128,
  parameter int WAIT_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic              long_in,
  input  logic              active,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  output logic              fin_o,
  output logic              tmo_o,
  output logic              crc_err_o,
  output logic [RESP_W-1:0] data_o
);

  localparam int SHORT_BITS = 47;
  localparam int LONG_BITS  = 135;
  localparam int CNT_MAX    = (LONG_BITS > WAIT_LIMIT) ? LONG_BITS : WAIT_LIMIT;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  logic              long_q, long_d, wait_q, wait_d, tmo_q, tmo_d, err_q, err_d, fb;
  logic [CNT_W-1:0]  cnt_q, cnt_d, nbits;
  logic [6:0]        crc_q, crc_d, rcrc_q, rcrc_d;
  logic [RESP_W-1:0] buf_q, buf_d;

  assign nbits = long_q ? CNT_W'(LONG_BITS) : CNT_W'(SHORT_BITS);
  assign fin_o = active & fall &
                 ((wait_q & (cnt_q == CNT_W'(WAIT_LIMIT))) | (~wait_q & (cnt_q == nbits)));
  assign fb    = din ^ crc_q[6];

  always_comb begin
    long_d = long_q; wait_d = wait_q; cnt_d = cnt_q; crc_d = crc_q;
    rcrc_d = rcrc_q; buf_d = buf_q; tmo_d = tmo_q; err_d = err_q;
    if (abort || start) begin
      long_d = start & long_in;
      wait_d = 1'b1; cnt_d = '0; crc_d = '0; rcrc_d = '0;
      buf_d  = '0; tmo_d = 1'b0; err_d = 1'b0;
    end else if (active && rise) begin
      if (wait_q) begin
        if (!din) begin
          wait_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d  = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q < nbits - CNT_W'(8)) begin
          buf_d = {buf_q[RESP_W-2:0], din};
          crc_d = {crc_q[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end else if (cnt_q < nbits - CNT_W'(1)) begin
          rcrc_d = {rcrc_q[5:0], din};
        end
        cnt_d = cnt_q + 1'b1;
      end
    end else if (fin_o) begin
      if (wait_q)                         tmo_d = 1'b1;
      else if (!long_q && rcrc_q != crc_q) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      long_q <= 1'b0; wait_q <= 1'b1; cnt_q <= '0; crc_q <= '0;
      rcrc_q <= '0;   buf_q <= '0;   tmo_q <= 1'b0; err_q <= 1'b0;
    end else begin
      long_q <= long_d; wait_q <= wait_d; cnt_q <= cnt_d; crc_q <= crc_d;
      rcrc_q <= rcrc_d; buf_q <= buf_d;   tmo_q <= tmo_d; err_q <= err_d;
    end
  end

  assign tmo_o     = tmo_q;
  assign crc_err_o = err_q;
  assign data_o    = buf_q;

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active && wait_q |-> cnt_q <= CNT_W'(WAIT_LIMIT)); // R8
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active && !wait_q |-> cnt_q <= nbits); // R6
  AST_LONG_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o && long_q |=> !crc_err_o); // R7

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int INIT_CLKS  = 74,
  parameter int TAIL_CLKS  = 8,
  parameter int WAIT_LIMIT = 64,
  parameter int RESP_W     = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [15:0]       ctl_wdata,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic              cmd_in,
  output logic              sd_clk,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              busy,
  output logic              done,
  output logic              resp_timeout,
  output logic              resp_crc_err,
  output logic [TRIG_W-1:0] trig_pend,
  output logic [RESP_W-1:0] resp_data
);

  localparam int BMAX   = (INIT_CLKS > TAIL_CLKS) ? INIT_CLKS : TAIL_CLKS;
  localparam int BCNT_W = $clog2(BMAX + 1);

  phase_e            st_q, st_d;
  logic [TRIG_W-1:0] trig_q, trig_d, clr_mask, trig_left;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic              keep_q, keep_d, done_q, done_d;
  logic              srst, wr, run, rise, fall, phase_end, enter;
  logic              tx_bit, tx_last, rx_fin;

  function automatic phase_e pick(input logic [TRIG_W-1:0] t);
    if (t[TB_INIT])                return ST_INIT;
    if (t[TB_CMD])                 return ST_CMD;
    if (t[TB_RSP] || t[TB_LONG])   return ST_RSP;
    if (t[TB_TAIL])                return ST_TAIL;
    return ST_IDLE;
  endfunction

  assign srst = ctl_we & ctl_wdata[CB_SRST];
  assign wr   = ctl_we & ~ctl_wdata[CB_SRST];
  assign run  = keep_q | (st_q != ST_IDLE) | sd_clk;

  always_comb begin
    clr_mask  = '0;
    phase_end = 1'b0;
    case (st_q)
      ST_INIT: begin
        clr_mask[TB_INIT] = 1'b1;
        phase_end = fall & (bcnt_q == BCNT_W'(INIT_CLKS - 1));
      end
      ST_TAIL: begin
        clr_mask[TB_TAIL] = 1'b1;
        phase_end = fall & (bcnt_q == BCNT_W'(TAIL_CLKS - 1));
      end
      ST_CMD: begin
        clr_mask[TB_CMD] = 1'b1;
        phase_end = tx_last;
      end
      ST_RSP: begin
        clr_mask[TB_RSP]  = 1'b1;
        clr_mask[TB_LONG] = 1'b1;
        phase_end = rx_fin;
      end
      default: ;
    endcase
  end

  always_comb begin
    trig_left = trig_q & ~(phase_end ? clr_mask : '0);
    trig_d    = srst ? '0 : (trig_left | (wr ? ctl_wdata[TRIG_W-1:0] : '0));
    keep_d    = srst ? 1'b0 : (wr ? ctl_wdata[CB_KEEP] : keep_q);
    idx_d     = wr ? ctl_wdata[CB_IDX +: IDX_W] : idx_q;
    st_d      = st_q;
    enter     = 1'b0;
    if (srst) begin
      st_d = ST_IDLE;
    end else if (st_q == ST_IDLE) begin
      if (pick(trig_q) != ST_IDLE && (keep_q ? sd_clk : ~sd_clk)) begin
        st_d  = pick(trig_q);
        enter = 1'b1;
      end
    end else if (phase_end) begin
      st_d  = pick(trig_left);
      enter = (st_d != ST_IDLE);
    end
    if (enter || srst)                                bcnt_d = '0;
    else if ((st_q == ST_INIT || st_q == ST_TAIL) && fall) bcnt_d = bcnt_q + 1'b1;
    else                                              bcnt_d = bcnt_q;
    done_d = ~srst & phase_end & (st_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      trig_q <= '0;
      keep_q <= 1'b0;
      idx_q  <= '0;
      bcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      trig_q <= trig_d;
      keep_q <= keep_d;
      idx_q  <= idx_d;
      bcnt_q <= bcnt_d;
      done_q <= done_d;
    end
  end

  sdcmd_clkgen u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .abort  (srst),
    .run    (run),
    .sd_clk (sd_clk),
    .rise   (rise),
    .fall   (fall)
  );

  sdcmd_tx u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .abort  (srst),
    .load   (enter && st_d == ST_CMD),
    .active (st_q == ST_CMD),
    .fall   (fall),
    .idx    (idx_q),
    .arg    (cmd_arg),
    .bit_o  (tx_bit),
    .last_o (tx_last)
  );

  sdcmd_rx #(.RESP_W(RESP_W), .WAIT_LIMIT(WAIT_LIMIT)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (srst),
    .start     (enter && st_d == ST_RSP),
    .long_in   (trig_left[TB_LONG]),
    .active    (st_q == ST_RSP),
    .rise      (rise),
    .fall      (fall),
    .din       (cmd_in),
    .fin_o     (rx_fin),
    .tmo_o     (resp_timeout),
    .crc_err_o (resp_crc_err),
    .data_o    (resp_data)
  );

  assign cmd_oe    = (st_q == ST_CMD);
  assign cmd_out   = cmd_oe ? tx_bit : 1'b1;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign trig_pend = trig_q;

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> trig_pend == '0 && !busy); // R12
  AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !phase_end |=> (trig_q & $past(trig_q)) == $past(trig_q)); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_INIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_INIT |-> bcnt_q < BCNT_W'(INIT_CLKS)); // R3
  AST_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (trig_q & 7'h73) == '0 && !keep_q |=> !busy); // R13

endmodule

// File: tb/sdcmd_seq_bench.sv
module sdcmd_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctl_we = 1'b0;
  logic [15:0]  ctl_wdata = '0;
  logic [31:0]  cmd_arg = '0;
  logic         cmd_in = 1'b1;
  logic         sd_clk, cmd_out, cmd_oe, busy, done, resp_timeout, resp_crc_err;
  logic [6:0]   trig_pend;
  logic [127:0] resp_data;

  int n_checks = 0;
  int n_fail   = 0;

  bit qc[$], qo[$], qd[$], qi[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdcmd_seq u_sdcmd_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cmd_arg(cmd_arg), .cmd_in(cmd_in), .sd_clk(sd_clk), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .busy(busy), .done(done), .resp_timeout(resp_timeout),
    .resp_crc_err(resp_crc_err), .trig_pend(trig_pend), .resp_data(resp_data)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // polynomial long division, generator 0x89
  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  task automatic add_burst(input int n);
    for (int j = 0; j < 2*n; j++) begin
      qc.push_back(j % 2); qo.push_back(0); qd.push_back(1); qi.push_back(1);
    end
  endtask

  task automatic add_cmd(input logic [5:0] idx, input logic [31:0] arg);
    logic [47:0] f;
    f = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
    for (int j = 0; j < 96; j++) begin
      qc.push_back(j % 2); qo.push_back(1); qd.push_back(f[47 - j/2]); qi.push_back(1);
    end
  endtask

  // d: high periods before start; nb: bits after start; tmo: no start at all
  task automatic add_rsp(input int d, input int nb, input logic [134:0] bits, input bit tmo);
    int len;
    bit v;
    len = tmo ? 128 : 2*(d + nb + 1);
    for (int j = 0; j < len; j++) begin
      int k;
      k = j / 2;
      if (tmo || k < d)       v = 1;
      else if (k == d)        v = 0;
      else if (k <= d + nb)   v = bits[nb - 1 - (k - d - 1)];
      else                    v = 1;
      qc.push_back(j % 2); qo.push_back(0); qd.push_back(1); qi.push_back(v);
    end
  endtask

  // runs the model schedule against the design, cycle by cycle
  task automatic run_seq(input string tag, input logic [15:0] w, input int mid,
                         input logic [15:0] mw, output logic [6:0] pend_mid);
    int errs;
    errs = 0;
    pend_mid = 'x;
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_we = 1'b0;
    for (int j = 0; j < qc.size(); j++) begin
      @(negedge clk);
      ctl_we = 1'b0;
      if (j == mid + 1) pend_mid = trig_pend;
      if (sd_clk !== qc[j] || cmd_oe !== qo[j] || cmd_out !== qd[j] ||
          busy !== 1'b1 || done !== 1'b0) begin
        if (errs == 0)
          $display("FAIL %s cycle %0d actual clk/oe/out/busy/done=%b%b%b%b%b expected=%b%b%b10",
                   tag, j, sd_clk, cmd_oe, cmd_out, busy, done, qc[j], qo[j], qd[j]);
        errs++;
      end
      cmd_in = qi[j];
      if (j == mid) begin ctl_we = 1'b1; ctl_wdata = mw; end
    end
    n_checks++;
    if (errs != 0) n_fail++;
    @(negedge clk);
    cmd_in = 1'b1;
    chk({tag, " done pulse"}, {busy, done}, 2'b01);
    @(negedge clk);
    chk({tag, " done single"}, {busy, done}, 2'b00);
    qc.delete(); qo.delete(); qd.delete(); qi.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [6:0]   pm;
    logic [134:0] rb;
    logic [119:0] content;
    logic [6:0]   c;
    int           tog;
    int           bcyc;
    bit           prev;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {sd_clk, cmd_oe, cmd_out, busy, done}, 5'b00100);
    chk("R1 reset pending", trig_pend, 7'h00);

    // R2 idle with keep=0: clock parked
    tog = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (sd_clk) tog++; end
    chk("R2 parked clock", tog, 0);

    // R3 init burst alone
    add_burst(74);
    run_seq("R3 init burst", 16'h0020, -1, 16'h0, pm);
    chk("R3 self clear", trig_pend, 7'h00);

    // R4 tail burst alone
    add_burst(8);
    run_seq("R4 tail burst", 16'h0040, -1, 16'h0, pm);
    chk("R4 self clear", trig_pend, 7'h00);

    // R5 command frames
    cmd_arg = 32'hDEADBEEF;
    add_cmd(6'h11, 32'hDEADBEEF);
    run_seq("R5 cmd 0x11", {2'b00, 6'h11, 8'h01}, -1, 16'h0, pm);
    chk("R5 self clear", trig_pend, 7'h00);
    cmd_arg = 32'h0;
    add_cmd(6'h3F, 32'h0);
    run_seq("R5 cmd 0x3F", {2'b00, 6'h3F, 8'h01}, -1, 16'h0, pm);

    // R6 command plus short response, start after 3 periods
    cmd_arg = 32'h12345678;
    c = ref_crc({2'b00, 6'h08, 32'h000001AA});
    rb = '0; rb[46:0] = {1'b0, 6'h08, 32'h000001AA, c, 1'b1};
    add_cmd(6'h08, 32'h12345678);
    add_rsp(3, 47, rb, 0);
    run_seq("R6 cmd+short rsp", {2'b00, 6'h08, 8'h03}, -1, 16'h0, pm);
    chk("R6 captured data", resp_data, {89'b0, 1'b0, 6'h08, 32'h000001AA});
    chk("R9 good crc no flag", {resp_crc_err, resp_timeout}, 2'b00);

    // R9 corrupted CRC, start immediately
    rb = '0; rb[46:0] = {1'b0, 6'h11, 32'h00000900, c ^ 7'h01, 1'b1};
    add_rsp(0, 47, rb, 0);
    run_seq("R9 bad crc rsp", 16'h0002, -1, 16'h0, pm);
    chk("R9 crc error flag", resp_crc_err, 1'b1);
    chk("R9 data still captured", resp_data, {89'b0, 1'b0, 6'h11, 32'h00000900});

    // R8 timeout on long response trigger
    add_rsp(0, 0, '0, 1);
    run_seq("R8 timeout", 16'h0012, -1, 16'h0, pm);
    chk("R8 timeout flag", {resp_timeout, resp_crc_err}, 2'b10);
    chk("R8 trigger cleared", trig_pend, 7'h00);

    // R7 long response, start on the last allowed edge
    content = {4{30'h2A5C_3B71}};
    rb = {1'b0, 6'h3F, content, 7'h55, 1'b1};
    add_rsp(63, 135, rb, 0);
    run_seq("R7 long rsp d63", 16'h0010, -1, 16'h0, pm);
    chk("R7 long data", resp_data, {1'b0, 1'b0, 6'h3F, content});
    chk("R7 no crc check", {resp_crc_err, resp_timeout}, 2'b00);

    // R10 + R11 full chain with a zero-trigger write inside the init burst
    cmd_arg = 32'hA5A5_0F0F;
    c = ref_crc({2'b00, 6'h02, 32'hCAFE_0001});
    rb = '0; rb[46:0] = {1'b0, 6'h02, 32'hCAFE_0001, c, 1'b1};
    add_burst(74);
    add_cmd(6'h02, 32'hA5A5_0F0F);
    add_rsp(1, 47, rb, 0);
    add_burst(8);
    run_seq("R10 ordered chain", {2'b00, 6'h02, 8'h63}, 20, {2'b00, 6'h02, 8'h00}, pm);
    chk("R11 zero write keeps pending", pm, 7'h63);
    chk("R10 rsp in chain", resp_data, {89'b0, 1'b0, 6'h02, 32'hCAFE_0001});
    chk("R10 all cleared", trig_pend, 7'h00);

    // R13 data request flags are pass-through only
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 16'h000C;
    @(negedge clk); ctl_we = 1'b0;
    tog = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (busy || sd_clk || done) tog++; end
    chk("R13 no phase started", tog, 0);
    chk("R13 flags pending", trig_pend, 7'h0C);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 16'h4000;
    @(negedge clk); ctl_we = 1'b0;
    chk("R12 srst clears data flags", trig_pend, 7'h00);

    // R12 abort an init burst
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 16'h0060;
    @(negedge clk); ctl_we = 1'b0;
    repeat (20) @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 16'h4000;
    @(negedge clk); ctl_we = 1'b0;
    chk("R12 abort idle", {busy, trig_pend}, 8'h00);
    tog = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (done || busy || sd_clk) tog++; end
    chk("R12 no done after abort", tog, 0);

    // R2 keep mode: free running clock, then a tail burst on top
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 16'h0080;
    @(negedge clk); ctl_we = 1'b0;
    @(negedge clk);
    prev = sd_clk; tog = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (sd_clk != prev) tog++; prev = sd_clk; end
    chk("R2 free running", tog, 10);
    ctl_we = 1'b1; ctl_wdata = 16'h00C0;
    @(negedge clk); ctl_we = 1'b0;
    bcyc = 0; tog = 0; prev = sd_clk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy) bcyc++;
      if (done) tog++;
    end
    chk("R4 keep burst length", bcyc, 16);
    chk("R4 keep single done", tog, 1);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 16'h0000;
    @(negedge clk); ctl_we = 1'b0;
    repeat (3) @(negedge clk);
    tog = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (sd_clk) tog++; end
    chk("R2 clock parks after keep off", tog, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule